// File: doc/BRIEF.md
# Partitioned Ping-Pong Buffer RAM Controller

This block owns a 4 KB buffer RAM that two masters share: a host processor port and a USB host-engine port. Software carves the RAM at run time into two regions with two length registers. The general region is a single flat area for control, bulk and interrupt payloads. The isochronous region is a pair of equal halves that are used ping-pong style. The processor fills or drains one half while the engine works on the other, and both can do so in the same cycle.

The length registers sit behind a small command interface. Each command is an 8-bit code, and a write code is its read code with bit 7 set. Every length write is checked against the RAM size. An illegal write is refused and leaves a sticky error that clears when it is read. Both masters address their data by region and byte offset. The block turns each offset into a physical word address and refuses any access that falls past the end of its region. A toggle pulse from the engine swaps the two isochronous halves. The processor is always steered to the half the engine is not using.

The RAM holds 32-bit words. Offsets are byte offsets whose two low bits are ignored, and lengths must be whole words.

Top module: `bpc_top`

## Requirements
- R1: After reset, both length registers read 0, the error flag reads 0 and the engine owns isochronous half 0 (`eng_iso_half` = 0).
- R2: Command 0xAB writes the general length and 0xAA writes the isochronous length from `cfg_wdata`, provided the result is legal. Commands 0x2B and 0x2A return those lengths on `cfg_rdata` one cycle after the command. The lengths change only on a legal write.
- R3: A length write is legal only if the value is a multiple of 4 and the general length plus twice the isochronous length stays at or below 0x1000. An illegal write leaves both lengths unchanged and sets the error flag.
- R4: Command 0x2C returns the error flag in bit 0 of `cfg_rdata` and clears it. Without that read, the flag stays set.
- R5: In the general region (region select 0), byte offset X maps to physical byte X. Both ports see the same data there.
- R6: The isochronous halves lie at physical bases G (half 0) and G+I (half 1), where G is the general length and I is the isochronous length.
- R7: A one-cycle `eng_toggle` pulse flips `eng_iso_half` on the next cycle. Engine isochronous accesses use half `eng_iso_half`, and processor isochronous accesses use the other half.
- R8: A read at an offset at or past the current length of its region returns 0 and raises that port's out-of-range flag.
- R9: A write at an offset at or past the current length of its region leaves the RAM unchanged and raises the out-of-range flag.
- R10: Read data and the out-of-range flag appear one cycle after the access. Read data holds until that port's next access.
- R11: A general length of 0x800 with an isochronous length of 0x400 is legal. The last word of half 1 then sits at physical byte 0xFFC.
- R12: Command codes other than 0x2A, 0x2B, 0x2C, 0xAA and 0xAB change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Command strobe |
| cfg_cmd | input | 8 | Command code |
| cfg_wdata | input | 16 | Length value for write commands |
| cfg_rdata | output | 16 | Result of the last read command |
| cfg_err | output | 1 | Sticky illegal-partition flag |
| cpu_en | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write enable |
| cpu_region | input | 1 | 0 general, 1 isochronous |
| cpu_off | input | 12 | Processor byte offset within region |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data |
| cpu_oor | output | 1 | Processor out-of-range flag |
| eng_en | input | 1 | Engine access strobe |
| eng_we | input | 1 | Engine write enable |
| eng_region | input | 1 | 0 general, 1 isochronous |
| eng_off | input | 12 | Engine byte offset within region |
| eng_wdata | input | 32 | Engine write data |
| eng_rdata | output | 32 | Engine read data |
| eng_oor | output | 1 | Engine out-of-range flag |
| eng_toggle | input | 1 | Swap isochronous half ownership |
| eng_iso_half | output | 1 | Isochronous half owned by the engine |

## Verification
Command reads, RAM reads and out-of-range flags each pass through one register, so each result is due one cycle after its strobe. The bench drives a strobe on a falling edge, drops it on the next falling edge and samples there, just after the capturing rising edge. A toggle takes effect on the cycle after the pulse, so `eng_iso_half` and the swapped routing are checked only after that edge. Cross-port reads, and reads made after repartitioning the general region to the full RAM, show the physical placement of every half at the ports.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam logic [7:0] CMD_ISO_RD  = 8'h2A;
  localparam logic [7:0] CMD_GEN_RD  = 8'h2B;
  localparam logic [7:0] CMD_STAT_RD = 8'h2C;
  localparam int         CMD_WR_BIT  = 7;
  localparam logic [7:0] CMD_ISO_WR  = CMD_ISO_RD | (8'h1 << CMD_WR_BIT);
  localparam logic [7:0] CMD_GEN_WR  = CMD_GEN_RD | (8'h1 << CMD_WR_BIT);

  typedef enum logic {
    RGN_GEN = 1'b0,
    RGN_ISO = 1'b1
  } region_e;

  localparam int NPORT  = 2;
  localparam int P_CPU  = 0;
  localparam int P_ENG  = 1;
endpackage

// File: rtl/bpc_len_regs.sv
module bpc_len_regs
  import bpc_pkg::*;
#(
  parameter int RAM_BYTES  = 4096,
  parameter int WORD_BYTES = 4,
  parameter int CFG_W      = 16,
  localparam int LEN_W     = $clog2(RAM_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [7:0]       cfg_cmd,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             cfg_err,
  output logic [LEN_W-1:0] gen_len,
  output logic [LEN_W-1:0] iso_len
);
  localparam int ALIGN_W = $clog2(WORD_BYTES);
  localparam int SUM_W   = CFG_W + 2;

  logic [LEN_W-1:0] gen_q, gen_d, iso_q, iso_d;
  logic             err_q, err_d;
  logic [CFG_W-1:0] rd_q, rd_d;
  logic [SUM_W-1:0] cand, gen_ext, iso_ext;
  logic             aligned, iso_ok, gen_ok;

  always_comb begin
    cand    = SUM_W'(cfg_wdata);
    gen_ext = SUM_W'(gen_q);
    iso_ext = SUM_W'(iso_q);
    aligned = (cfg_wdata[ALIGN_W-1:0] == '0);
    iso_ok  = aligned && ((gen_ext + (cand << 1)) <= SUM_W'(RAM_BYTES));
    gen_ok  = aligned && ((cand + (iso_ext << 1)) <= SUM_W'(RAM_BYTES));
    gen_d = gen_q;
    iso_d = iso_q;
    err_d = err_q;
    rd_d  = rd_q;
    if (cfg_valid) begin
      case (cfg_cmd)
        CMD_ISO_WR: if (iso_ok) iso_d = cand[LEN_W-1:0]; else err_d = 1'b1;
        CMD_GEN_WR: if (gen_ok) gen_d = cand[LEN_W-1:0]; else err_d = 1'b1;
        CMD_ISO_RD: rd_d = CFG_W'(iso_q);
        CMD_GEN_RD: rd_d = CFG_W'(gen_q);
        CMD_STAT_RD: begin
          rd_d  = CFG_W'(err_q);
          err_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
      iso_q <= '0;
      err_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      gen_q <= gen_d;
      iso_q <= iso_d;
      err_q <= err_d;
      rd_q  <= rd_d;
    end
  end

  assign gen_len   = gen_q;
  assign iso_len   = iso_q;
  assign cfg_err   = err_q;
  assign cfg_rdata = rd_q;
endmodule

// File: rtl/bpc_addr_map.sv
module bpc_addr_map
  import bpc_pkg::*;
#(
  parameter int RAM_BYTES  = 4096,
  parameter int WORD_BYTES = 4,
  localparam int ADDR_W    = $clog2(RAM_BYTES),
  localparam int LEN_W     = ADDR_W + 1,
  localparam int ALIGN_W   = $clog2(WORD_BYTES),
  localparam int WA_W      = ADDR_W - ALIGN_W
) (
  input  region_e          region,
  input  logic             half,
  input  logic [ADDR_W-1:0] off,
  input  logic [LEN_W-1:0] gen_len,
  input  logic [LEN_W-1:0] iso_len,
  output logic [WA_W-1:0]  word_addr,
  output logic             in_range
);
  logic [LEN_W-1:0] off_ext, lim, base, phys;
  logic             unused_bits;

  always_comb begin
    off_ext = LEN_W'(off);
    if (region == RGN_ISO) begin
      lim  = iso_len;
      base = half ? (gen_len + iso_len) : gen_len;
    end else begin
      lim  = gen_len;
      base = '0;
    end
    in_range  = (off_ext < lim);
    phys      = base + off_ext;
    word_addr = phys[ADDR_W-1:ALIGN_W];
  end

  assign unused_bits = ^{phys[LEN_W-1], phys[ALIGN_W-1:0]};
endmodule

// File: rtl/bpc_ram.sv
module bpc_ram
  import bpc_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             we,
  input  logic [NPORT-1:0]             re,
  input  logic [NPORT-1:0][AW-1:0]     addr,
  input  logic [NPORT-1:0][DATA_W-1:0] wdata,
  output logic [NPORT-1:0][DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Later port in the loop wins a same-word write: the engine.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[p] <= '0;
      else if (re[p]) q[p] <= mem[addr[p]];
    end
  end
endmodule

// File: rtl/bpc_top.sv
module bpc_top
  import bpc_pkg::*;
#(
  parameter int RAM_BYTES  = 4096,
  parameter int WORD_BYTES = 4,
  parameter int CFG_W      = 16,
  localparam int ADDR_W    = $clog2(RAM_BYTES),
  localparam int LEN_W     = ADDR_W + 1,
  localparam int DATA_W    = 8 * WORD_BYTES,
  localparam int DEPTH     = RAM_BYTES / WORD_BYTES,
  localparam int WA_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [7:0]        cfg_cmd,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              cfg_err,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic              cpu_region,
  input  logic [ADDR_W-1:0] cpu_off,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_oor,
  input  logic              eng_en,
  input  logic              eng_we,
  input  logic              eng_region,
  input  logic [ADDR_W-1:0] eng_off,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              eng_oor,
  input  logic              eng_toggle,
  output logic              eng_iso_half
);
  logic [LEN_W-1:0] gen_len, iso_len;
  logic             half_q, half_d;

  logic [NPORT-1:0]             p_en, p_we, p_half, p_in, p_oor_q, p_oor_d;
  logic [NPORT-1:0]             ram_we, ram_re;
  logic [NPORT-1:0]             p_region;
  logic [NPORT-1:0][ADDR_W-1:0] p_off;
  logic [NPORT-1:0][WA_W-1:0]   p_wa;
  logic [NPORT-1:0][DATA_W-1:0] p_wdata, ram_q;

  bpc_len_regs #(.RAM_BYTES(RAM_BYTES), .WORD_BYTES(WORD_BYTES), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .gen_len(gen_len), .iso_len(iso_len)
  );

  // Ownership of the isochronous halves
  always_comb begin
    half_d = half_q;
    if (eng_toggle) half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  assign eng_iso_half = half_q;

  // Gather both masters into port arrays
  assign p_en     = {eng_en, cpu_en};
  assign p_we     = {eng_we, cpu_we};
  assign p_region = {eng_region, cpu_region};
  assign p_off    = {eng_off, cpu_off};
  assign p_wdata  = {eng_wdata, cpu_wdata};
  assign p_half   = {half_q, ~half_q};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    bpc_addr_map #(.RAM_BYTES(RAM_BYTES), .WORD_BYTES(WORD_BYTES)) u_map (
      .region(region_e'(p_region[p])), .half(p_half[p]), .off(p_off[p]),
      .gen_len(gen_len), .iso_len(iso_len),
      .word_addr(p_wa[p]), .in_range(p_in[p])
    );

    always_comb begin
      ram_we[p]  = p_en[p] &  p_we[p] & p_in[p];
      ram_re[p]  = p_en[p] & ~p_we[p] & p_in[p];
      p_oor_d[p] = p_en[p] & ~p_in[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_oor_q[p] <= 1'b0;
      else        p_oor_q[p] <= p_oor_d[p];
    end
  end

  bpc_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .re(ram_re),
    .addr(p_wa), .wdata(p_wdata), .q(ram_q)
  );

  assign cpu_oor   = p_oor_q[P_CPU];
  assign eng_oor   = p_oor_q[P_ENG];
  assign cpu_rdata = p_oor_q[P_CPU] ? '0 : ram_q[P_CPU];
  assign eng_rdata = p_oor_q[P_ENG] ? '0 : ram_q[P_ENG];
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker
  import bpc_pkg::*;
#(
  parameter int RAM_BYTES  = 4096,
  parameter int WORD_BYTES = 4,
  parameter int CFG_W      = 16,
  localparam int LEN_W     = $clog2(RAM_BYTES) + 1,
  localparam int DATA_W    = 8 * WORD_BYTES,
  localparam int SUM_W     = LEN_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic [7:0]       cfg_cmd,
  input logic             cfg_err,
  input logic [LEN_W-1:0] gen_len,
  input logic [LEN_W-1:0] iso_len,
  input logic             cpu_en,
  input logic             cpu_oor,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic             eng_en,
  input logic             eng_oor,
  input logic [DATA_W-1:0] eng_rdata,
  input logic             eng_toggle,
  input logic             eng_iso_half
);
  logic stat_rd;
  assign stat_rd = cfg_valid && (cfg_cmd == CMD_STAT_RD);

  AST_PART_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (SUM_W'(gen_len) + (SUM_W'(iso_len) << 1)) <= SUM_W'(RAM_BYTES)); // R3
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> ($stable(gen_len) && $stable(iso_len))); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !stat_rd) |=> cfg_err); // R4
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !cfg_err); // R4
  AST_CPU_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_oor |-> (cpu_rdata == '0)); // R8
  AST_ENG_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    eng_oor |-> (eng_rdata == '0)); // R8
  AST_CPU_OOR_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_oor |-> $past(cpu_en)); // R10
  AST_ENG_OOR_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    eng_oor |-> $past(eng_en)); // R10
  AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_toggle |=> (eng_iso_half != $past(eng_iso_half))); // R7
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_toggle |=> $stable(eng_iso_half)); // R7
endmodule

bind bpc_top bpc_checker #(.RAM_BYTES(RAM_BYTES), .WORD_BYTES(WORD_BYTES), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd), .cfg_err(cfg_err),
  .gen_len(gen_len), .iso_len(iso_len),
  .cpu_en(cpu_en), .cpu_oor(cpu_oor), .cpu_rdata(cpu_rdata),
  .eng_en(eng_en), .eng_oor(eng_oor), .eng_rdata(eng_rdata),
  .eng_toggle(eng_toggle), .eng_iso_half(eng_iso_half)
);

// File: tb/sim_bpc_top.sv
`timescale 1ns/1ps
module sim_bpc_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_valid;
  logic [7:0]  cfg_cmd;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        cfg_err;
  logic        cpu_en, cpu_we, cpu_region;
  logic [11:0] cpu_off;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_oor;
  logic        eng_en, eng_we, eng_region;
  logic [11:0] eng_off;
  logic [31:0] eng_wdata, eng_rdata;
  logic        eng_oor, eng_toggle, eng_iso_half;

  int n_chk = 0;
  int n_err = 0;

  bpc_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_region(cpu_region), .cpu_off(cpu_off),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_oor(cpu_oor),
    .eng_en(eng_en), .eng_we(eng_we), .eng_region(eng_region), .eng_off(eng_off),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_oor(eng_oor),
    .eng_toggle(eng_toggle), .eng_iso_half(eng_iso_half)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {cmd, wdata, expected general length, expected iso length, expected error}
  localparam int NVEC = 13;
  localparam logic [63:0] VEC [NVEC] = '{
    {8'hAB, 16'h0800, 16'h0800, 16'h0000, 8'h00},
    {8'hAA, 16'h0400, 16'h0800, 16'h0400, 8'h00},
    {8'hAA, 16'h0401, 16'h0800, 16'h0400, 8'h01},
    {8'hAB, 16'h0804, 16'h0800, 16'h0400, 8'h01},
    {8'hAA, 16'h0000, 16'h0800, 16'h0000, 8'h00},
    {8'hAB, 16'h1000, 16'h1000, 16'h0000, 8'h00},
    {8'hAA, 16'h0004, 16'h1000, 16'h0000, 8'h01},
    {8'hAB, 16'h0000, 16'h0000, 16'h0000, 8'h00},
    {8'hAA, 16'h0800, 16'h0000, 16'h0800, 8'h00},
    {8'hAB, 16'h0004, 16'h0000, 16'h0800, 8'h01},
    {8'hAA, 16'h0000, 16'h0000, 16'h0000, 8'h00},
    {8'hAB, 16'hFFFC, 16'h0000, 16'h0000, 8'h01},
    {8'hAC, 16'h0001, 16'h0000, 16'h0000, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_op(input logic [7:0] cmd, input logic [15:0] data);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_cmd = cmd; cfg_wdata = data;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic cpu_acc(input logic we, input logic rgn, input logic [11:0] off,
                         input logic [31:0] data);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = we; cpu_region = rgn; cpu_off = off; cpu_wdata = data;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic eng_acc(input logic we, input logic rgn, input logic [11:0] off,
                         input logic [31:0] data);
    @(negedge clk);
    eng_en = 1'b1; eng_we = we; eng_region = rgn; eng_off = off; eng_wdata = data;
    @(negedge clk);
    eng_en = 1'b0; eng_we = 1'b0;
  endtask

  task automatic dual_wr(input logic [11:0] coff, input logic [31:0] cdat,
                         input logic [11:0] eoff, input logic [31:0] edat);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_region = 1'b1; cpu_off = coff; cpu_wdata = cdat;
    eng_en = 1'b1; eng_we = 1'b1; eng_region = 1'b1; eng_off = eoff; eng_wdata = edat;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0; eng_en = 1'b0; eng_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_cmd = '0; cfg_wdata = '0;
    cpu_en = 1'b0; cpu_we = 1'b0; cpu_region = 1'b0; cpu_off = '0; cpu_wdata = '0;
    eng_en = 1'b0; eng_we = 1'b0; eng_region = 1'b0; eng_off = '0; eng_wdata = '0;
    eng_toggle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 half", 32'(eng_iso_half), 32'h0);
    chk("R1 err", 32'(cfg_err), 32'h0);
    cfg_op(8'h2B, '0); chk("R1 gen", 32'(cfg_rdata), 32'h0);
    cfg_op(8'h2A, '0); chk("R1 iso", 32'(cfg_rdata), 32'h0);

    // Table walk: R2 legal writes, R3 rejections, R4 clear on read, R12 unknown code
    for (int i = 0; i < NVEC; i++) begin
      cfg_op(VEC[i][63:56], VEC[i][55:40]);
      cfg_op(8'h2B, '0); chk(VEC[i][7:0] != 0 ? "R3 gen" : "R2 gen", 32'(cfg_rdata), 32'(VEC[i][39:24]));
      cfg_op(8'h2A, '0); chk(VEC[i][7:0] != 0 ? "R3 iso" : "R2 iso", 32'(cfg_rdata), 32'(VEC[i][23:8]));
      cfg_op(8'h2C, '0); chk("R4 status", 32'(cfg_rdata), 32'(VEC[i][7:0]));
    end

    // R4 sticky across idle cycles, then cleared by one read
    cfg_op(8'hAA, 16'h2000);
    repeat (4) @(negedge clk);
    chk("R4 sticky", 32'(cfg_err), 32'h1);
    cfg_op(8'h2C, '0); chk("R4 read", 32'(cfg_rdata), 32'h1);
    chk("R4 cleared", 32'(cfg_err), 32'h0);

    // Mapping: G=0x100, I=0x80, engine on half 0
    cfg_op(8'hAB, 16'h0100);
    cfg_op(8'hAA, 16'h0080);
    dual_wr(12'h010, 32'hAAAA0001, 12'h010, 32'hBBBB0002);
    cpu_acc(1'b1, 1'b0, 12'h020, 32'hCCCC0003);
    eng_acc(1'b0, 1'b1, 12'h010, '0); chk("R6 eng half0", eng_rdata, 32'hBBBB0002);
    cpu_acc(1'b0, 1'b1, 12'h010, '0); chk("R6 cpu half1", cpu_rdata, 32'hAAAA0001);
    eng_acc(1'b0, 1'b0, 12'h020, '0); chk("R5 shared", eng_rdata, 32'hCCCC0003);
    @(negedge clk); chk("R10 hold", eng_rdata, 32'hCCCC0003);

    // R7 swap
    @(negedge clk); eng_toggle = 1'b1;
    @(negedge clk); eng_toggle = 1'b0;
    chk("R7 half", 32'(eng_iso_half), 32'h1);
    eng_acc(1'b0, 1'b1, 12'h010, '0); chk("R7 eng", eng_rdata, 32'hAAAA0001);
    cpu_acc(1'b0, 1'b1, 12'h010, '0); chk("R7 cpu", cpu_rdata, 32'hBBBB0002);

    // Physical layout seen through a full-size general region
    cfg_op(8'hAA, 16'h0000);
    cfg_op(8'hAB, 16'h1000);
    cpu_acc(1'b0, 1'b0, 12'h190, '0); chk("R6 phys half1", cpu_rdata, 32'hAAAA0001);
    cpu_acc(1'b0, 1'b0, 12'h110, '0); chk("R6 phys half0", cpu_rdata, 32'hBBBB0002);
    cpu_acc(1'b0, 1'b0, 12'h020, '0); chk("R5 phys", cpu_rdata, 32'hCCCC0003);

    // Out of range: G=0x100, I=0x80, engine on half 1, processor on half 0 at 0x100
    cfg_op(8'hAB, 16'h0100);
    cfg_op(8'hAA, 16'h0080);
    cpu_acc(1'b1, 1'b1, 12'h000, 32'hEEEE0005);
    chk("R9 in range flag", 32'(cpu_oor), 32'h0);
    cpu_acc(1'b1, 1'b0, 12'h100, 32'hDDDD0004);
    chk("R9 flag", 32'(cpu_oor), 32'h1);
    cpu_acc(1'b0, 1'b1, 12'h000, '0);
    chk("R9 unchanged", cpu_rdata, 32'hEEEE0005);
    chk("R10 flag drop", 32'(cpu_oor), 32'h0);
    cpu_acc(1'b0, 1'b0, 12'h100, '0);
    chk("R8 cpu data", cpu_rdata, 32'h0);
    chk("R8 cpu flag", 32'(cpu_oor), 32'h1);
    eng_acc(1'b0, 1'b1, 12'h080, '0);
    chk("R8 eng data", eng_rdata, 32'h0);
    chk("R8 eng flag", 32'(eng_oor), 32'h1);

    // R11 full use of the RAM
    cfg_op(8'hAA, 16'h0000);
    cfg_op(8'hAB, 16'h0800);
    cfg_op(8'hAA, 16'h0400);
    cfg_op(8'h2C, '0); chk("R11 legal", 32'(cfg_rdata), 32'h0);
    eng_acc(1'b1, 1'b1, 12'h3FC, 32'hF00D0006);
    chk("R11 last word flag", 32'(eng_oor), 32'h0);
    eng_acc(1'b1, 1'b1, 12'h400, 32'h12345678);
    chk("R11 past end", 32'(eng_oor), 32'h1);
    cfg_op(8'hAA, 16'h0000);
    cfg_op(8'hAB, 16'h1000);
    cpu_acc(1'b0, 1'b0, 12'hFFC, '0); chk("R11 phys", cpu_rdata, 32'hF00D0006);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule